// File: doc/BRIEF.md
# Register-Driven SPI Command Engine

This block is an SPI master that a host controls through eight byte-wide registers. The host loads an opcode, up to three address bytes and one spare data byte. It then writes a control byte. That single write picks how many bytes go out on the wire (1, 2, 4 or 5), how many bytes come back (0 to 3) and which of two serial clock rates to use. The engine then runs one chip-select frame on its own. The host polls a busy flag, and once busy clears it reads the returned bytes from the top three registers.

The same control register also switches a memory-mapped write mode on and off. Only the mode flag and its speed bit are kept here. The memory-cycle path that would use them lives elsewhere. The host port is a plain register port with no back-pressure: a write always completes in one cycle. Flow control is the busy flag alone, and while it is set every host write is dropped.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, every register reads 0x00, chip select is high, the serial clock is low, busy is clear and the memory-mapped mode flag is off.
- R2: While idle, writes to offsets 1 to 7 are stored and read back unchanged. Offset 0 reads busy in bit 7, the memory-mapped mode flag in bit 6, and zero in bits 5 to 0.
- R3: A write to offset 0 while idle, with bits [7:4] equal to 0x4 (slow clock) or 0x5 (fast clock), starts a frame. Busy reads as set on the cycle after that write, and chip select is low by then. Any other upper nibble starts nothing.
- R4: In the start byte, bits [1:0] give the bytes sent (0→1, 1→2, 2→4, 3→5) and bits [3:2] give the bytes read back (0 to 3). The frame carries exactly 8 × (sent + read) clock pulses.
- R5: Bytes go out MSB first. Offset 1 (the opcode) always goes first. A 2-byte command then sends offset 7. A 4-byte command sends offsets 4, 3, 2. A 5-byte command sends offsets 4, 3, 2, then 7.
- R6: SPI mode 0. The clock idles low whenever chip select is high. MOSI changes only when the clock falls or when chip select falls. Chip select stays low without a break from the first sent bit to the last read bit.
- R7: MISO is sampled on each rising clock edge. The read-back bytes land in offsets 5, 6, 7 in wire order. Offsets past the read count keep their earlier contents.
- R8: Each half period of the serial clock lasts DIV_SLOW or DIV_FAST system cycles. Busy stays set for exactly 2 × DIV × bits + 1 cycles, and it clears one cycle after chip select rises.
- R9: While busy, all host writes are ignored. This covers a second start and data register writes.
- R10: Control value 0x20 turns the memory-mapped mode on with the slow flag, 0x30 turns it on with the fast flag, and 0x00 turns it off. No other control value changes the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| mmap_on | output | 1 | Memory-mapped write mode active |
| mmap_fast | output | 1 | Speed selected for memory-mapped mode |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Some properties are checked on every cycle: the clock idles low outside a frame, MOSI changes only on a falling clock edge or at frame start, a frame begins only from idle, and busy covers the whole frame and clears after chip select rises. The mode flag updates on the 0x20, 0x30 and 0x00 writes are also checked each cycle. Other behaviour only the bench scenarios can show. This includes the byte order on the wire for each length code, where the read-back bytes land, the exact length of busy at both speeds, and the fact that writes made during a frame leave no trace afterwards.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int TX_BYTES_MAX = 5;
  localparam int RX_BYTES_MAX = 3;
  localparam int FRAME_W      = 8 * TX_BYTES_MAX;
  localparam int RXSR_W       = 8 * RX_BYTES_MAX;
  localparam int NBITS_W      = 7;

  localparam logic [3:0] NIB_GO_SLOW = 4'h4;
  localparam logic [3:0] NIB_GO_FAST = 4'h5;
  localparam logic [7:0] CTL_MAP_SLOW = 8'h20;
  localparam logic [7:0] CTL_MAP_FAST = 8'h30;
  localparam logic [7:0] CTL_MAP_OFF  = 8'h00;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_DONE} eng_state_t;

  function automatic logic [3:0] wlen_bytes(input logic [1:0] code);
    case (code)
      2'd0: return 4'd1;
      2'd1: return 4'd2;
      2'd2: return 4'd4;
      default: return 4'd5;
    endcase
  endfunction
endpackage

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [2:0]         addr,
  input  logic [7:0]         wdata,
  input  logic               busy,
  input  logic               rx_valid,
  input  logic [RXSR_W-1:0]  rx_data,
  output logic [7:0]         rdata,
  output logic               start,
  output logic [FRAME_W-1:0] frame,
  output logic [NBITS_W-1:0] nbits,
  output logic               spd_fast,
  output logic               mmap_on,
  output logic               mmap_fast
);
  logic [7:0] regs_q [0:7];
  logic [1:0] rcnt_q;
  logic       ctrl_wr;
  logic [3:0] nbytes;

  assign ctrl_wr = we && !busy && (addr == 3'd0);
  assign start   = ctrl_wr && ((wdata[7:4] == NIB_GO_SLOW) || (wdata[7:4] == NIB_GO_FAST));
  assign nbytes  = wlen_bytes(wdata[1:0]) + {2'b00, wdata[3:2]};
  assign nbits   = {nbytes, 3'b000};

  // Wire image of the command, left aligned; address bytes leave high offset first.
  always_comb begin
    case (wdata[1:0])
      2'd0:    frame = {regs_q[1], 32'h0};
      2'd1:    frame = {regs_q[1], regs_q[7], 24'h0};
      2'd2:    frame = {regs_q[1], regs_q[4], regs_q[3], regs_q[2], 8'h0};
      default: frame = {regs_q[1], regs_q[4], regs_q[3], regs_q[2], regs_q[7]};
    endcase
  end

  assign rdata = (addr == 3'd0) ? {busy, mmap_on, 6'b0} : regs_q[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) regs_q[i] <= 8'h00;
      rcnt_q    <= 2'd0;
      spd_fast  <= 1'b0;
      mmap_on   <= 1'b0;
      mmap_fast <= 1'b0;
    end else begin
      if (we && !busy && (addr != 3'd0)) regs_q[addr] <= wdata;
      if (start) begin
        spd_fast <= (wdata[7:4] == NIB_GO_FAST);
        rcnt_q   <= wdata[3:2];
      end else if (ctrl_wr) begin
        if (wdata == CTL_MAP_SLOW) begin
          mmap_on <= 1'b1; mmap_fast <= 1'b0;
        end else if (wdata == CTL_MAP_FAST) begin
          mmap_on <= 1'b1; mmap_fast <= 1'b1;
        end else if (wdata == CTL_MAP_OFF) begin
          mmap_on <= 1'b0;
        end
      end
      // The earliest byte received sits highest in the shift register.
      if (rx_valid) begin
        for (int j = 0; j < RX_BYTES_MAX; j++) begin
          if (j < int'(rcnt_q))
            regs_q[5+j] <= rx_data[8*(int'(rcnt_q)-1-j) +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV_SLOW = 4,
  parameter int DIV_FAST = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fast,
  output logic tick
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW      = $clog2(DIV_MAX + 1);
  localparam logic [CW-1:0] LIM_SLOW = CW'(DIV_SLOW - 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(DIV_FAST - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit = fast ? LIM_FAST : LIM_SLOW;
  assign tick  = en && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl
  import spi_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [NBITS_W-1:0] nbits,
  input  logic               tick,
  input  logic               miso,
  output logic               cs_n,
  output logic               sck,
  output logic               mosi,
  output logic               busy,
  output logic               shifting,
  output logic               rx_valid,
  output logic [RXSR_W-1:0]  rx_data
);
  eng_state_t           state_q;
  logic [FRAME_W-1:0]   tx_q;
  logic [NBITS_W-2:0]   left_q;

  assign busy     = (state_q != ST_IDLE);
  assign shifting = (state_q == ST_SHIFT);
  assign mosi     = tx_q[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cs_n     <= 1'b1;
      sck      <= 1'b0;
      tx_q     <= '0;
      left_q   <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_SHIFT;
          cs_n    <= 1'b0;
          sck     <= 1'b0;
          tx_q    <= frame;
          left_q  <= (NBITS_W-1)'(nbits - 1'b1);
        end
        ST_SHIFT: if (tick) begin
          if (!sck) begin
            sck     <= 1'b1;
            rx_data <= {rx_data[RXSR_W-2:0], miso};
          end else begin
            sck <= 1'b0;
            if (left_q == '0) begin
              cs_n     <= 1'b1;
              state_q  <= ST_DONE;
              rx_valid <= 1'b1;
            end else begin
              tx_q   <= tx_q << 1;
              left_q <= left_q - 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int DIV_SLOW = 4,
  parameter int DIV_FAST = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       mmap_on,
  output logic       mmap_fast,
  output logic       spi_cs_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic               busy;
  logic               start;
  logic               shifting;
  logic               tick;
  logic               spd_fast;
  logic               rx_valid;
  logic [RXSR_W-1:0]  rx_data;
  logic [FRAME_W-1:0] frame;
  logic [NBITS_W-1:0] nbits;

  spi_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .rx_valid(rx_valid), .rx_data(rx_data), .rdata(reg_rdata),
    .start(start), .frame(frame), .nbits(nbits), .spd_fast(spd_fast),
    .mmap_on(mmap_on), .mmap_fast(mmap_fast)
  );

  spi_tick_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(shifting), .fast(spd_fast), .tick(tick)
  );

  spi_shift_ctrl u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .frame(frame), .nbits(nbits),
    .tick(tick), .miso(spi_miso), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .busy(busy), .shifting(shifting), .rx_valid(rx_valid), .rx_data(rx_data)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       busy,
  input logic       mmap_on,
  input logic       mmap_fast,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       spi_mosi
);
  // R3: a valid start from idle opens a frame on the next cycle
  a_r3_start_opens_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && !busy &&
     (reg_wdata[7:4] == 4'h4 || reg_wdata[7:4] == 4'h5)) |=> (busy && !spi_cs_n));

  // R6: clock idles low outside a frame
  a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R6: MOSI moves only with a falling clock or at frame start
  a_r6_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_mosi) |-> ($fell(spi_sck) || $fell(spi_cs_n)));

  // R8: chip select low implies busy; busy ends after chip select rises
  a_r8_cs_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
  a_r8_busy_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (spi_cs_n && $past(spi_cs_n)));

  // R9: a frame only begins from idle
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(!busy));

  // R10: memory-mapped mode flag updates
  a_r10_map_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && !busy && reg_wdata == 8'h20) |=> (mmap_on && !mmap_fast));
  a_r10_map_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && !busy && reg_wdata == 8'h30) |=> (mmap_on && mmap_fast));
  a_r10_map_off: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0 && !busy && reg_wdata == 8'h00) |=> !mmap_on);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (.*);

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
  localparam int DIV_SLOW = 4;
  localparam int DIV_FAST = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       mmap_on, mmap_fast, spi_cs_n, spi_sck, spi_mosi;
  logic       spi_miso = 1'b0;

  int n_cmp = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  spi_cmd_engine #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mmap_on(mmap_on),
    .mmap_fast(mmap_fast), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // Behavioural mode-0 slave: records MOSI, returns a seeded byte stream
  logic [7:0] slv_base = 8'h00;
  logic [7:0] cap [0:7];
  int         sbit = 0;
  logic       prev_cs = 1'b1;
  logic       prev_sck = 1'b0;

  function automatic logic [7:0] slv_byte(input logic [7:0] base, input int b);
    return base ^ (8'h5A + 8'(b * 19));
  endfunction

  always @(spi_cs_n or spi_sck) begin
    logic [7:0] t;
    if (!spi_cs_n && prev_cs) begin
      sbit = 0;
      for (int i = 0; i < 8; i++) cap[i] = 8'h00;
    end
    if (!spi_cs_n) begin
      if (spi_sck && !prev_sck) begin
        if (sbit < 64) cap[sbit/8][7-(sbit%8)] = spi_mosi;
        sbit++;
      end else if (!spi_sck && sbit < 64) begin
        t = slv_byte(slv_base, sbit / 8);
        spi_miso = t[7-(sbit%8)];
      end
    end
    prev_cs  = spi_cs_n;
    prev_sck = spi_sck;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic int wbytes(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 5;
    endcase
  endfunction

  task automatic do_cmd(input logic [1:0] wc, input logic [1:0] rc, input logic fast,
                        input bit poke);
    logic [7:0] b [0:7];
    logic [7:0] tx [0:4];
    logic [7:0] v;
    logic [7:0] e;
    int nw, cyc, div;
    for (int i = 1; i < 8; i++) begin
      b[i] = 8'($urandom);
      wr(3'(i), b[i]);
    end
    slv_base = 8'($urandom);
    nw = wbytes(wc);
    tx[0] = b[1];
    case (wc)
      2'd1: tx[1] = b[7];
      2'd2: begin tx[1] = b[4]; tx[2] = b[3]; tx[3] = b[2]; end
      2'd3: begin tx[1] = b[4]; tx[2] = b[3]; tx[3] = b[2]; tx[4] = b[7]; end
      default: ;
    endcase
    div = fast ? DIV_FAST : DIV_SLOW;
    wr(3'd0, {fast ? 4'h5 : 4'h4, rc, wc});
    rd(3'd0, v);
    chk("R3 busy after start", {31'b0, v[7]}, 1);
    chk("R3 cs low after start", {31'b0, spi_cs_n}, 0);
    if (!poke) begin
      cyc = 0;
      while (reg_rdata[7] && cyc < 5000) begin
        cyc++;
        @(negedge clk); #1;
      end
      chk("R8 busy duration", cyc, 2 * div * 8 * (nw + int'(rc)) + 1);
    end else begin
      wr(3'd0, 8'h5F);
      wr(3'd1, 8'hEE);
      reg_addr = 3'd0; #1;
      cyc = 0;
      while (reg_rdata[7] && cyc < 5000) begin
        cyc++;
        @(negedge clk); #1;
      end
      for (int k = 0; k < 10; k++) begin
        @(negedge clk); #1;
        chk("R9 no second frame", {30'b0, reg_rdata[7], spi_cs_n}, 1);
      end
    end
    chk("R4 clock pulse count", sbit, 8 * (nw + int'(rc)));
    chk("R6 cs high after frame", {31'b0, spi_cs_n}, 1);
    for (int i = 0; i < nw; i++) chk("R5 wire byte", cap[i], tx[i]);
    for (int j = 0; j < 3; j++) begin
      e = (j < int'(rc)) ? slv_byte(slv_base, nw + j) : b[5+j];
      rd(3'(5 + j), v);
      chk("R7 read-back register", v, e);
    end
    for (int i = 1; i < 5; i++) begin
      rd(3'(i), v);
      e = (poke || i != 1) ? b[i] : b[i];
      chk(poke ? "R9 write during busy dropped" : "R2 data register kept", v, e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL R8 watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_err + 1);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk("R1 reset register", v, 8'h00);
    end
    chk("R1 reset pins", {28'b0, spi_cs_n, spi_sck, mmap_on, mmap_fast}, 32'h8);
    // R2 readback while idle
    wr(3'd6, 8'hC3);
    rd(3'd6, v);
    chk("R2 readback", v, 8'hC3);
    // R3 / R10 non-start control values
    wr(3'd0, 8'h6A);
    rd(3'd0, v);
    chk("R3 bad nibble no start", {24'b0, v}, 0);
    chk("R3 bad nibble cs", {31'b0, spi_cs_n}, 1);
    // R10 memory-mapped mode
    wr(3'd0, 8'h20);
    chk("R10 map slow", {30'b0, mmap_on, mmap_fast}, 2);
    rd(3'd0, v);
    chk("R2 status mode bit", v, 8'h40);
    wr(3'd0, 8'h30);
    chk("R10 map fast", {30'b0, mmap_on, mmap_fast}, 3);
    wr(3'd0, 8'h3C);
    chk("R10 other value keeps mode", {30'b0, mmap_on, mmap_fast}, 3);
    wr(3'd0, 8'h00);
    chk("R10 map off", {31'b0, mmap_on}, 0);
    // Directed corners of R4 / R5 / R7 / R8
    do_cmd(2'd0, 2'd0, 1'b0, 1'b0);
    do_cmd(2'd3, 2'd3, 1'b1, 1'b0);
    do_cmd(2'd1, 2'd3, 1'b0, 1'b0);
    do_cmd(2'd2, 2'd0, 1'b1, 1'b0);
    do_cmd(2'd0, 2'd3, 1'b1, 1'b0);
    do_cmd(2'd3, 2'd1, 1'b0, 1'b0);
    // R9 writes during busy
    do_cmd(2'd2, 2'd2, 1'b0, 1'b1);
    // Random mix
    for (int n = 0; n < 40; n++)
      do_cmd(2'($urandom), 2'($urandom), 1'($urandom), 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule